// File: doc/BRIEF.md
# Receive Holding Queue with Flow Control

This block sits behind a serial receiver and holds up to three received characters until the CPU reads them. Each stored character keeps its own framing-error, parity-error and break flags. The receiver side delivers a one-cycle character strobe with the data and flags, and a pulse for each detected start bit. The CPU side sees the head character and consumes it with a read strobe. A reset-error command clears the sticky error state.

Three configuration inputs set the behaviour:

- **Interrupt source.** The interrupt output follows either "character available" or "queue full".
- **Error reporting.** Status shows either the head entry's own flags or a running OR of the flags of every entry that has reached the head since the last reset-error command.
- **Flow control.** The active-low request-to-send output follows a software bit. When automatic flow control is on, a start bit seen while the queue is full forces the output inactive. The software bit is not changed, so the output becomes active again as soon as an entry is read out.

Top module: `rx_hold_fifo`

## Requirements
- R1: The queue keeps up to 3 characters in arrival order. `rd_data` shows the oldest one, `rdy` is high when at least one is held, and `full` is high when 3 are held. A `cpu_rd` pulse removes the oldest entry at the clock edge. A `cpu_rd` pulse while the queue is empty changes nothing.
- R2: Each entry keeps the framing, parity and break flags that arrived with its character. In per-character mode, reading earlier entries out exposes each later entry's own flags unchanged.
- R3: With `cfg_auto_rts`=1, a `start_seen` pulse while `full`=1 drives `rts_n` high from the next cycle. This holds for as long as the queue stays full, even with `sw_rts`=1.
- R4: After such a forced drop, `rts_n` returns to `!sw_rts` in the same cycle that `full` falls, with no change to `sw_rts`.
- R5: With `cfg_auto_rts`=0, `rts_n` equals `!sw_rts` at all times, and `start_seen` has no effect on it.
- R6: With `cfg_irq_full`=0, `irq` equals `rdy`. With `cfg_irq_full`=1, `irq` equals `full`.
- R7: With `cfg_err_block`=0, the outputs {`st_brk`,`st_pe`,`st_fe`} show the flags of the head entry, and they are all 0 when the queue is empty.
- R8: With `cfg_err_block`=1, the status outputs show the OR of the flags of every entry that has become head since the last `err_clr`. They keep that value after those entries are read out.
- R9: An `err_clr` pulse clears the accumulated status and `overrun` at that clock edge. If an entry becomes head at the same edge, its flags are included after the clear. If an overflow happens at the same edge, `overrun` is set.
- R10: A character strobe while `full`=1 is discarded, even if a read happens in the same cycle. It sets `overrun`, which stays set until `err_clr`, and the stored entries are not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chr_valid | input | 1 | One-cycle strobe: a received character is presented |
| chr_data | input | DW | Received character |
| chr_fe | input | 1 | Framing error of the presented character |
| chr_pe | input | 1 | Parity error of the presented character |
| chr_brk | input | 1 | Break flag of the presented character |
| start_seen | input | 1 | Pulse: receiver detected a valid start bit |
| cpu_rd | input | 1 | CPU read strobe, removes the head entry |
| err_clr | input | 1 | Reset-error command |
| cfg_auto_rts | input | 1 | 1 enables automatic request-to-send drop |
| cfg_irq_full | input | 1 | Interrupt source: 0 = character available, 1 = queue full |
| cfg_err_block | input | 1 | Error status: 0 = per character, 1 = accumulated |
| sw_rts | input | 1 | Software request-to-send bit (1 = assert) |
| rd_data | output | DW | Head character |
| rdy | output | 1 | Queue not empty |
| full | output | 1 | Queue full |
| st_fe | output | 1 | Reported framing error |
| st_pe | output | 1 | Reported parity error |
| st_brk | output | 1 | Reported break |
| overrun | output | 1 | Sticky overflow flag |
| irq | output | 1 | Receive interrupt |
| rts_n | output | 1 | Request-to-send, active low |

## Verification
A wrong entry count shows at `rdy` and `full` at the very next edge, and it shows at `rts_n` and `irq` whenever flow control or the full-interrupt mode is selected. A wrong pointer or a lost entry shows on `rd_data` at the next read that reaches it, within three reads. Error flags stored with the wrong entry show at the status outputs in per-character mode, in the cycle that entry becomes head. An accumulator that misses a head arrival, or that clears at the wrong edge, stays wrong until the next `err_clr`. The bench therefore compares every output after every edge against a queue model, across long mixed sequences of pushes, reads and clears.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef struct packed {
    logic brk;
    logic pe;
    logic fe;
  } rxq_flags_t;

  function automatic rxq_flags_t flags_merge(input rxq_flags_t a, input rxq_flags_t b);
    rxq_flags_t r;
    r.brk = a.brk | b.brk;
    r.pe  = a.pe  | b.pe;
    r.fe  = a.fe  | b.fe;
    return r;
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic [DW-1:0] push_data,
  input  rxq_flags_t    push_flags,
  input  logic          rd_req,
  output logic [DW-1:0] head_data,
  output rxq_flags_t    head_flags,
  output logic          not_empty,
  output logic          is_full,
  output logic          pop,
  output logic          overflow,
  output logic          head_arrive,
  output rxq_flags_t    arrive_flags
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

  logic [DW-1:0] data_mem [DEPTH];
  rxq_flags_t    flag_mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count, count_next;
  logic          push_ok;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [CW-1:0] cnt_step(input logic [CW-1:0] c,
                                             input logic inc, input logic dec);
    logic [CW-1:0] r;
    r = c;
    if (inc && !dec) r = c + 1'b1;
    if (dec && !inc) r = c - 1'b1;
    return r;
  endfunction

  assign not_empty  = (count != '0);
  assign is_full    = (count == CNT_MAX);
  assign pop        = rd_req & not_empty;
  assign push_ok    = push_req & ~is_full;
  assign overflow   = push_req & is_full;
  assign count_next = cnt_step(count, push_ok, pop);
  assign head_data  = data_mem[rd_ptr];
  assign head_flags = flag_mem[rd_ptr];

  // a new entry becomes head: push into empty queue, or pop leaving entries behind
  assign head_arrive = (!not_empty && push_ok) || (pop && count_next != '0);

  always_comb begin
    if (pop && count > CW'(1)) arrive_flags = flag_mem[ptr_next(rd_ptr)];
    else                       arrive_flags = push_flags;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_next(wr_ptr);
      if (pop)     rd_ptr <= ptr_next(rd_ptr);
      count <= count_next;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_mem[i] <= '0;
        flag_mem[i] <= '0;
      end else if (push_ok && wr_ptr == PW'(i)) begin
        data_mem[i] <= push_data;
        flag_mem[i] <= push_flags;
      end
    end
  end

  AST_COUNT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_MAX); // R1
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!not_empty && !push_req) |=> !not_empty); // R1
  AST_OVF_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && is_full && !rd_req) |=> (is_full && $stable(head_data))); // R10

endmodule

// File: rtl/rxq_err.sv
module rxq_err
  import rxq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       block_mode,
  input  logic       not_empty,
  input  rxq_flags_t head_flags,
  input  logic       head_arrive,
  input  rxq_flags_t arrive_flags,
  output rxq_flags_t status
);

  rxq_flags_t acc, acc_base, acc_next;

  assign acc_base = clr ? '0 : acc;
  assign acc_next = head_arrive ? flags_merge(acc_base, arrive_flags) : acc_base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc <= '0;
    else        acc <= acc_next;
  end

  always_comb begin
    if (block_mode)     status = acc;
    else if (not_empty) status = head_flags;
    else                status = '0;
  end

  AST_CHAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (!block_mode && !not_empty) |-> (status == '0)); // R7
  AST_ACC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((acc & $past(acc)) == $past(acc))); // R8
  AST_CLR_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !head_arrive) |=> (acc == '0)); // R9

endmodule

// File: rtl/rxq_rts.sv
module rxq_rts (
  input  logic clk,
  input  logic rst_n,
  input  logic auto_en,
  input  logic start_seen,
  input  logic is_full,
  input  logic sw_rts,
  output logic drop_active,
  output logic rts_n
);

  logic hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold <= 1'b0;
    else        hold <= auto_en & is_full & (hold | start_seen);
  end

  assign drop_active = auto_en & hold & is_full;
  assign rts_n       = ~sw_rts | drop_active;

  AST_RTS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !is_full |-> (rts_n == !sw_rts)); // R4
  AST_RTS_MANUAL: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |-> (rts_n == !sw_rts)); // R5

endmodule

// File: rtl/rx_hold_fifo.sv
module rx_hold_fifo
  import rxq_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chr_valid,
  input  logic [DW-1:0] chr_data,
  input  logic          chr_fe,
  input  logic          chr_pe,
  input  logic          chr_brk,
  input  logic          start_seen,
  input  logic          cpu_rd,
  input  logic          err_clr,
  input  logic          cfg_auto_rts,
  input  logic          cfg_irq_full,
  input  logic          cfg_err_block,
  input  logic          sw_rts,
  output logic [DW-1:0] rd_data,
  output logic          rdy,
  output logic          full,
  output logic          st_fe,
  output logic          st_pe,
  output logic          st_brk,
  output logic          overrun,
  output logic          irq,
  output logic          rts_n
);

  rxq_flags_t in_flags, head_flags, arrive_flags, status;
  logic       pop, overflow, head_arrive, drop_active;

  assign in_flags.brk = chr_brk;
  assign in_flags.pe  = chr_pe;
  assign in_flags.fe  = chr_fe;

  rxq_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .push_req(chr_valid), .push_data(chr_data), .push_flags(in_flags),
    .rd_req(cpu_rd),
    .head_data(rd_data), .head_flags(head_flags),
    .not_empty(rdy), .is_full(full), .pop(pop), .overflow(overflow),
    .head_arrive(head_arrive), .arrive_flags(arrive_flags)
  );

  rxq_err u_err (
    .clk(clk), .rst_n(rst_n), .clr(err_clr), .block_mode(cfg_err_block),
    .not_empty(rdy), .head_flags(head_flags),
    .head_arrive(head_arrive), .arrive_flags(arrive_flags),
    .status(status)
  );

  rxq_rts u_rts (
    .clk(clk), .rst_n(rst_n), .auto_en(cfg_auto_rts), .start_seen(start_seen),
    .is_full(full), .sw_rts(sw_rts), .drop_active(drop_active), .rts_n(rts_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) overrun <= 1'b0;
    else        overrun <= (overrun & ~err_clr) | overflow;
  end

  assign st_fe  = status.fe;
  assign st_pe  = status.pe;
  assign st_brk = status.brk;
  assign irq    = cfg_irq_full ? full : rdy;

  AST_RTS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_auto_rts && start_seen && full && !cpu_rd) |=> rts_n); // R3
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !err_clr) |=> overrun); // R10
  AST_POP_ONLY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> rdy); // R1
  AST_DROP_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    drop_active |-> full); // R3

endmodule

// File: tb/rx_hold_fifo_test.sv
module rx_hold_fifo_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chr_valid = 0, chr_fe = 0, chr_pe = 0, chr_brk = 0;
  logic [7:0] chr_data = '0;
  logic start_seen = 0, cpu_rd = 0, err_clr = 0;
  logic cfg_auto_rts = 0, cfg_irq_full = 0, cfg_err_block = 0, sw_rts = 0;
  logic [7:0] rd_data;
  logic rdy, full, st_fe, st_pe, st_brk, overrun, irq, rts_n;

  always #2.5 clk = ~clk;

  rx_hold_fifo uut (
    .clk(clk), .rst_n(rst_n), .chr_valid(chr_valid), .chr_data(chr_data),
    .chr_fe(chr_fe), .chr_pe(chr_pe), .chr_brk(chr_brk), .start_seen(start_seen),
    .cpu_rd(cpu_rd), .err_clr(err_clr), .cfg_auto_rts(cfg_auto_rts),
    .cfg_irq_full(cfg_irq_full), .cfg_err_block(cfg_err_block), .sw_rts(sw_rts),
    .rd_data(rd_data), .rdy(rdy), .full(full), .st_fe(st_fe), .st_pe(st_pe),
    .st_brk(st_brk), .overrun(overrun), .irq(irq), .rts_n(rts_n)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // scoreboard: {brk,pe,fe,data}
  logic [10:0] exp_q[$];
  logic [2:0]  m_acc = '0;
  bit          m_ovr = 0, m_hold = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input bit push, input logic [7:0] d, input logic [2:0] f,
                     input bit rd, input bit clr, input bit st);
    bit was_full, was_empty, acc_ok, popd, arrive;
    was_full  = (exp_q.size() == 3);
    was_empty = (exp_q.size() == 0);
    popd      = rd && !was_empty;
    // monitor: the head being consumed must match the scoreboard
    if (popd) check("R1 R2 popped data", rd_data, exp_q[0][7:0]);
    chr_valid = push; chr_data = d; {chr_brk, chr_pe, chr_fe} = f;
    cpu_rd = rd; err_clr = clr; start_seen = st;
    acc_ok = push && (exp_q.size() < 3);
    m_hold = cfg_auto_rts && was_full && (m_hold || st);
    @(posedge clk);
    #1;
    chr_valid = 0; cpu_rd = 0; err_clr = 0; start_seen = 0;
    if (clr) begin m_acc = '0; m_ovr = 0; end
    if (push && !acc_ok) m_ovr = 1;
    if (popd) void'(exp_q.pop_front());
    if (acc_ok) exp_q.push_back({f, d});
    arrive = (was_empty && acc_ok) || (popd && exp_q.size() > 0);
    if (arrive) m_acc = m_acc | exp_q[0][10:8];
    #0.5;
    check("R1 rdy", rdy, exp_q.size() > 0);
    check("R1 full", full, exp_q.size() == 3);
    if (exp_q.size() > 0) check("R1 head data", rd_data, exp_q[0][7:0]);
    check("R10 R9 overrun", overrun, m_ovr);
    if (cfg_err_block) check("R8 R9 block status", {st_brk, st_pe, st_fe}, m_acc);
    else check("R7 R2 char status", {st_brk, st_pe, st_fe},
               exp_q.size() > 0 ? exp_q[0][10:8] : 3'b000);
    check("R6 irq", irq, cfg_irq_full ? (exp_q.size() == 3) : (exp_q.size() > 0));
    if (cfg_auto_rts) check("R3 R4 rts", rts_n, !sw_rts || (m_hold && exp_q.size() == 3));
    else              check("R5 rts", rts_n, !sw_rts);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    #12 rst_n = 1'b1;
    @(posedge clk); #1;
    // reset state
    check("R1 reset rdy", rdy, 0);
    check("R1 reset full", full, 0);
    check("R10 reset overrun", overrun, 0);
    check("R7 reset status", {st_brk, st_pe, st_fe}, 0);
    check("R5 reset rts", rts_n, 1);
    // R5: software bit drives rts_n directly
    sw_rts = 1; #0.5;
    check("R5 sw assert", rts_n, 0);
    // fill: A(fe) B(pe) C(brk)
    cyc(1, 8'hA1, 3'b001, 0, 0, 0);
    cyc(1, 8'hB2, 3'b010, 0, 0, 0);
    cyc(1, 8'hC3, 3'b100, 0, 0, 0);
    cfg_irq_full = 1; #0.5;
    check("R6 irq full sel", irq, 1);
    // R10: overflow discarded, overflow with read also discarded
    cyc(1, 8'hD4, 3'b111, 0, 0, 0);
    check("R10 head kept", rd_data, 8'hA1);
    // R5: start with auto off does nothing
    cyc(0, 0, 0, 0, 0, 1);
    check("R5 start ignored", rts_n, 0);
    // R3: auto drop
    cfg_auto_rts = 1;
    cyc(0, 0, 0, 0, 0, 1);
    check("R3 dropped", rts_n, 1);
    cyc(0, 0, 0, 0, 0, 0);
    check("R3 still dropped", rts_n, 1);
    cyc(1, 8'hE5, 3'b000, 1, 0, 0);  // read A, push discarded (R10)
    check("R4 reasserted", rts_n, 0);
    check("R10 discard on read", full, 0);
    cfg_irq_full = 0;
    cyc(0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 1, 0, 0);           // R1 read on empty
    check("R1 empty read", rdy, 0);
    // block mode
    cfg_err_block = 1;
    cyc(0, 0, 0, 0, 1, 0);
    check("R9 overrun cleared", overrun, 0);
    cyc(1, 8'h11, 3'b001, 0, 0, 0);
    cyc(1, 8'h22, 3'b010, 0, 0, 0);
    cyc(0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 1, 0, 0);
    check("R8 kept after drain", {st_brk, st_pe, st_fe}, 3'b011);
    cyc(1, 8'h33, 3'b100, 0, 1, 0);  // clear with arrival same edge
    check("R9 clear plus arrival", {st_brk, st_pe, st_fe}, 3'b100);
    // mixed traffic
    lf = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (i % 97 == 0) begin
        cfg_err_block = lf[3]; cfg_irq_full = lf[4];
        cfg_auto_rts = lf[5]; sw_rts = lf[6];
      end
      cyc(lf[0] | lf[7], lf[15:8], lf[11:9], lf[1] & lf[8], (lf[14:12] == 3'b0), lf[2]);
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule